// File: doc/BRIEF.md
# SDRAM Device-Side Command Decoder with Two-Bank State

This block sits behind the pins of a synchronous DRAM device model. On every rising clock edge it samples the strobes, the address word, the bank select bit, the clock-enable and the data mask. It turns the strobe pattern into one command and checks that command against the open or closed state of two banks. Commands that break the bank rules are refused and flagged, and accepted commands update the bank state.

Accepted commands are presented one cycle later as a registered record. The record carries a command code, a mask of the banks the command touches, the row or column it carries, and the auto-close request. The block also keeps a countdown per bank, so a bank opened for a burst with auto-close returns to idle when the burst ends.

Alongside the command path the block drives the data-path controls. A read high-impedance control follows the mask two edges late. A write enable and a write mask act in the same edge as the data. The clock-enable input freezes the whole decoder with one edge of delay. Self-refresh entry and exit are tracked as their own state.

Top module: `sdcd_top`

## Requirements
- R1: With cs_n low, the strobe pattern {ras_n,cas_n,we_n} is classified as 011 open-row, 101 read, 100 write, 010 close-bank, 110 burst stop, 001 refresh, 000 mode load, 111 no-op. An accepted command other than the no-op sets cmd_valid for one cycle after the sampling edge, with cmd_code 1 open-row, 2 read, 3 write, 4 close, 5 burst stop, 6 refresh, 7 mode load.
- R2: With cs_n high, no command is taken (cmd_valid and illegal stay low), yet auto-close countdowns and write bursts already running keep advancing.
- R3: An accepted open-row marks the bank named by bank_sel active (bank_active bit index equals bank_sel) and reports the full address word in cmd_addr and that one bank in cmd_banks.
- R4: An accepted read or write reports addr[COL_W-1:0] zero-extended in cmd_addr and reports the top address bit (addr[ADDR_W-1]) as cmd_autopre.
- R5: A close-bank with addr[ADDR_W-1] high idles both banks and reports cmd_banks = 11; with it low only the bank named by bank_sel is idled and reported. Closing an idle bank is legal.
- R6: A read or write to an idle bank, an open-row to an active bank, or a refresh or mode load while any bank is active raises illegal for one cycle with cmd_valid low and leaves bank_active unchanged.
- R7: A read or write accepted at edge k with auto-close set returns its bank to idle at edge k+BURST_LEN, provided no other command to that bank intervenes.
- R8: rd_hiz after edge k+1 equals dqm sampled at edge k, so the mask governs read data two edges after it is sampled.
- R9: wr_en and wr_mask are combinational and mark the BURST_LEN write data slots, at edges k to k+BURST_LEN-1 after a write accepted at edge k. In a slot, wr_en is high when dqm is low and wr_mask is high when dqm is high.
- R10: An accepted read, burst stop or close-bank ends a running write burst, and the edge that carries it is not a write slot.
- R11: A command at edge k is acted on only if cke was high at edge k-1. While frozen, bank state, countdowns and the dqm pipeline hold, and cmd_valid, illegal, wr_en and wr_mask stay low.
- R12: A refresh sampled with cke low, while the decoder is running and both banks are idle, is accepted as self-refresh entry and raises self_refresh after that edge. self_refresh falls after the first edge that samples cke high.
- R13: After reset, cmd_valid, illegal, bank_active, self_refresh, wr_en and wr_mask are low and rd_hiz is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, acts one edge late |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Row or column word; top bit is the auto-close / all-banks bit |
| bank_sel | input | 1 | Bank select (0 = bank 0, 1 = bank 1) |
| dqm | input | 1 | Data mask |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_code | output | 3 | Code of the accepted command |
| cmd_banks | output | 2 | Banks touched by the accepted command |
| cmd_addr | output | ADDR_W | Row, or zero-extended column |
| cmd_autopre | output | 1 | Auto-close request of an accepted read or write |
| illegal | output | 1 | Rule-breaking command strobe |
| bank_active | output | 2 | Open state per bank |
| self_refresh | output | 1 | Self-refresh state |
| rd_hiz | output | 1 | Read output high-impedance control |
| wr_en | output | 1 | Write slot with data enabled |
| wr_mask | output | 1 | Write slot with data masked |

## Verification
The command record, illegal, bank_active, self_refresh and rd_hiz are registers, so the bench drives on the falling edge and reads them 1 ns after the next rising edge. That is the first point where a command sampled at that edge is visible. wr_en and wr_mask respond within the same cycle, so they are read half a nanosecond after the inputs change and before the edge that would consume the data. The auto-close countdown is watched at every one of the BURST_LEN edges, so an early or late release is caught. The mask pipeline is checked on the second edge after a one-cycle pulse, and the freeze is checked by feeding mask pulses and commands during the two edges that cke lag makes dead.

// File: rtl/sdcd_pkg.sv
package sdcd_pkg;

   typedef enum logic [2:0] {
      SD_NOP = 3'd0,
      SD_ACT = 3'd1,
      SD_RD  = 3'd2,
      SD_WR  = 3'd3,
      SD_PRE = 3'd4,
      SD_BST = 3'd5,
      SD_REF = 3'd6,
      SD_MRS = 3'd7
   } sd_cmd_e;

   localparam int SD_NUM_BANKS = 2;

endpackage

// File: rtl/sdcd_classify.sv
module sdcd_classify
   import sdcd_pkg::*;
(
   input  logic    cs_n,
   input  logic    ras_n,
   input  logic    cas_n,
   input  logic    we_n,
   output logic    sel,
   output sd_cmd_e cmd
);

   assign sel = ~cs_n;

   always_comb begin
      unique case ({ras_n, cas_n, we_n})
         3'b011:  cmd = SD_ACT;
         3'b101:  cmd = SD_RD;
         3'b100:  cmd = SD_WR;
         3'b010:  cmd = SD_PRE;
         3'b110:  cmd = SD_BST;
         3'b001:  cmd = SD_REF;
         3'b000:  cmd = SD_MRS;
         default: cmd = SD_NOP;
      endcase
   end

endmodule

// File: rtl/sdcd_bank_trk.sv
module sdcd_bank_trk #(
   parameter int BURST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic open_i,
   input  logic close_i,
   input  logic rw_i,
   input  logic autopre_i,
   output logic active_o
);

   localparam int CNT_W = $clog2(BURST_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN);

   logic [CNT_W-1:0] ap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         ap_cnt   <= '0;
      end else if (en) begin
         if (close_i) begin
            active_o <= 1'b0;
            ap_cnt   <= '0;
         end else if (open_i) begin
            active_o <= 1'b1;
            ap_cnt   <= '0;
         end else if (rw_i) begin
            ap_cnt   <= autopre_i ? CNT_LOAD : '0;
         end else if (ap_cnt == CNT_W'(1)) begin
            active_o <= 1'b0;
            ap_cnt   <= '0;
         end else if (ap_cnt != '0) begin
            ap_cnt   <= ap_cnt - 1'b1;
         end
      end
   end

   AST_OPEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      en && open_i && !close_i |=> active_o); // R3

   AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      en && close_i |=> !active_o); // R5

   AST_AP_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      en && ap_cnt == CNT_W'(1) && !open_i && !rw_i |=> !active_o); // R7

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(active_o)); // R11

endmodule

// File: rtl/sdcd_dq_ctl.sv
module sdcd_dq_ctl #(
   parameter int BURST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic dqm,
   input  logic wr_start,
   input  logic wr_stop,
   output logic rd_hiz,
   output logic wr_en,
   output logic wr_mask
);

   localparam int REM_W = $clog2(BURST_LEN + 1);

   logic [REM_W-1:0] wr_rem;
   logic             dqm_d1;
   logic             slot;
   logic [1:0]       fill;

   generate
      if (BURST_LEN == 1) begin : g_single
         assign wr_rem = '0;
      end else begin : g_multi
         localparam logic [REM_W-1:0] REM_LOAD = REM_W'(BURST_LEN - 1);
         logic [REM_W-1:0] rem_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     rem_q <= '0;
            else if (en) begin
               if (wr_start)                rem_q <= REM_LOAD;
               else if (wr_stop)            rem_q <= '0;
               else if (rem_q != '0)        rem_q <= rem_q - 1'b1;
            end
         end
         assign wr_rem = rem_q;
      end
   endgenerate

   assign slot    = en & (wr_start | ((wr_rem != '0) & ~wr_stop));
   assign wr_en   = slot & ~dqm;
   assign wr_mask = slot &  dqm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dqm_d1 <= 1'b1;
         rd_hiz <= 1'b1;
         fill   <= 2'd0;
      end else if (en) begin
         dqm_d1 <= dqm;
         rd_hiz <= dqm_d1;
         if (fill != 2'd2) fill <= fill + 2'd1;
      end
   end

   AST_HIZ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fill == 2'd2 && $past(en) && $past(en, 2) |-> rd_hiz == $past(dqm, 2)); // R8

   AST_NO_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !wr_en && !wr_mask); // R11

   AST_STOP_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stop && !wr_start |-> !wr_en && !wr_mask); // R10

endmodule

// File: rtl/sdcd_top.sv
module sdcd_top
   import sdcd_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int COL_W     = 8,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              bank_sel,
   input  logic              dqm,
   output logic              cmd_valid,
   output logic [2:0]        cmd_code,
   output logic [1:0]        cmd_banks,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_autopre,
   output logic              illegal,
   output logic [1:0]        bank_active,
   output logic              self_refresh,
   output logic              rd_hiz,
   output logic              wr_en,
   output logic              wr_mask
);

   localparam int NB     = SD_NUM_BANKS;
   localparam int AP_BIT = ADDR_W - 1;

   generate
      if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_col
         $error("sdcd_top: COL_W must lie in 1..ADDR_W-1");
      end
      if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("sdcd_top: BURST_LEN must be 1, 2, 4 or 8");
      end
   endgenerate

   logic    cke_q;
   logic    en;
   logic    sel;
   sd_cmd_e cmd;
   logic    is_rw;
   logic    acc;
   logic    bad;
   logic    good;
   logic    tgt_act;
   logic    any_act;
   logic [NB-1:0] bank_hot;
   logic [NB-1:0] pre_mask;
   logic [NB-1:0] act_q;

   sdcd_classify u_cls (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .sel   (sel),
      .cmd   (cmd)
   );

   assign en       = cke_q;
   assign is_rw    = (cmd == SD_RD) || (cmd == SD_WR);
   assign bank_hot = NB'(1) << bank_sel;
   assign pre_mask = addr[AP_BIT] ? {NB{1'b1}} : bank_hot;
   assign tgt_act  = act_q[bank_sel];
   assign any_act  = |act_q;
   assign acc      = en && sel && (cmd != SD_NOP);
   assign bad      = acc && (((cmd == SD_ACT) && tgt_act) ||
                             (is_rw && !tgt_act) ||
                             (((cmd == SD_REF) || (cmd == SD_MRS)) && any_act));
   assign good     = acc && !bad;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         sdcd_bank_trk #(.BURST_LEN(BURST_LEN)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en),
            .open_i    (good && (cmd == SD_ACT) && bank_hot[b]),
            .close_i   (good && (cmd == SD_PRE) && pre_mask[b]),
            .rw_i      (good && is_rw && bank_hot[b]),
            .autopre_i (addr[AP_BIT]),
            .active_o  (act_q[b])
         );
      end
   endgenerate

   assign bank_active = act_q;

   sdcd_dq_ctl #(.BURST_LEN(BURST_LEN)) u_dq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .dqm      (dqm),
      .wr_start (good && (cmd == SD_WR)),
      .wr_stop  (good && ((cmd == SD_RD) || (cmd == SD_BST) || (cmd == SD_PRE))),
      .rd_hiz   (rd_hiz),
      .wr_en    (wr_en),
      .wr_mask  (wr_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_q        <= 1'b1;
         cmd_valid    <= 1'b0;
         illegal      <= 1'b0;
         cmd_code     <= SD_NOP;
         cmd_banks    <= '0;
         cmd_addr     <= '0;
         cmd_autopre  <= 1'b0;
         self_refresh <= 1'b0;
      end else begin
         cke_q     <= cke;
         cmd_valid <= good;
         illegal   <= bad;
         if (acc) cmd_code <= cmd;
         if (good) begin
            unique case (cmd)
               SD_ACT: begin
                  cmd_banks   <= bank_hot;
                  cmd_addr    <= addr;
                  cmd_autopre <= 1'b0;
               end
               SD_RD, SD_WR: begin
                  cmd_banks   <= bank_hot;
                  cmd_addr    <= ADDR_W'(addr[COL_W-1:0]);
                  cmd_autopre <= addr[AP_BIT];
               end
               SD_PRE: begin
                  cmd_banks   <= pre_mask;
                  cmd_addr    <= '0;
                  cmd_autopre <= 1'b0;
               end
               default: begin
                  cmd_banks   <= '0;
                  cmd_addr    <= '0;
                  cmd_autopre <= 1'b0;
               end
            endcase
         end
         if (self_refresh && cke)                  self_refresh <= 1'b0;
         else if (good && (cmd == SD_REF) && !cke) self_refresh <= 1'b1;
      end
   end

   AST_ACT_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      en && sel && cmd == SD_ACT && act_q[bank_sel] |=> illegal && !cmd_valid); // R6

   AST_RW_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      en && sel && (cmd == SD_RD || cmd == SD_WR) && !act_q[bank_sel] |=> illegal && !cmd_valid); // R6

   AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !cmd_valid && !illegal); // R11

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !cmd_valid && !illegal); // R2

   AST_SRF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      self_refresh && cke |=> !self_refresh); // R12

endmodule

// File: tb/sdcd_top_tb.sv
`timescale 1ns/1ps
module sdcd_top_tb;
   import sdcd_pkg::*;

   localparam int AW = 11;
   localparam int CW = 8;
   localparam int BL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic bank_sel = 1'b0, dqm = 1'b0;
   logic cmd_valid, cmd_autopre, illegal, self_refresh, rd_hiz, wr_en, wr_mask;
   logic [2:0] cmd_code;
   logic [1:0] cmd_banks, bank_active;
   logic [AW-1:0] cmd_addr;
   logic s_wr_en, s_wr_mask;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sdcd_top #(.ADDR_W(AW), .COL_W(CW), .BURST_LEN(BL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .bank_sel(bank_sel), .dqm(dqm),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_banks(cmd_banks),
      .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre), .illegal(illegal),
      .bank_active(bank_active), .self_refresh(self_refresh), .rd_hiz(rd_hiz),
      .wr_en(wr_en), .wr_mask(wr_mask)
   );

   typedef struct packed {
      logic [2:0] cmd;
      logic       bank;
      logic       a10;
      logic       ev;
      logic       ei;
      logic [1:0] emask;
      logic [1:0] eact;
   } vec_t;

   // R1 R3 R5 R6: commands from the idle state, legal and illegal
   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{SD_NOP, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00},
      '{SD_RD,  1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00},
      '{SD_ACT, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b01},
      '{SD_ACT, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01},
      '{SD_MRS, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01},
      '{SD_ACT, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 2'b11},
      '{SD_RD,  1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b11},
      '{SD_PRE, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 2'b01},
      '{SD_REF, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01},
      '{SD_PRE, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 2'b00},
      '{SD_REF, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00},
      '{SD_MRS, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00},
      '{SD_BST, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00},
      '{SD_WR,  1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00},
      '{SD_PRE, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 2'b00}
   };

   function automatic logic [2:0] pins(input logic [2:0] c);
      case (c)
         SD_ACT:  return 3'b011;
         SD_RD:   return 3'b101;
         SD_WR:   return 3'b100;
         SD_PRE:  return 3'b010;
         SD_BST:  return 3'b110;
         SD_REF:  return 3'b001;
         SD_MRS:  return 3'b000;
         default: return 3'b111;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic k, input logic c, input logic [2:0] code,
                       input logic b, input logic [AW-1:0] a, input logic m);
      @(negedge clk);
      cke = k; cs_n = c; {ras_n, cas_n, we_n} = pins(code);
      bank_sel = b; addr = a; dqm = m;
      #0.5;
      s_wr_en = wr_en; s_wr_mask = wr_mask;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R13 actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R13 cmd_valid", cmd_valid, 0);
      chk("R13 illegal", illegal, 0);
      chk("R13 bank_active", bank_active, 0);
      chk("R13 self_refresh", self_refresh, 0);
      chk("R13 rd_hiz", rd_hiz, 1);
      chk("R13 wr_en", wr_en, 0);
      chk("R13 wr_mask", wr_mask, 0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(1'b1, 1'b0, TBL[i].cmd, TBL[i].bank, {TBL[i].a10, 10'h000}, 1'b0);
         chk($sformatf("R1 vec%0d cmd_valid", i), cmd_valid, TBL[i].ev);
         chk($sformatf("R6 vec%0d illegal", i), illegal, TBL[i].ei);
         chk($sformatf("R3 vec%0d bank_active", i), bank_active, TBL[i].eact);
         if (TBL[i].ev) begin
            chk($sformatf("R1 vec%0d cmd_code", i), cmd_code, TBL[i].cmd);
            chk($sformatf("R5 vec%0d cmd_banks", i), cmd_banks, TBL[i].emask);
         end
      end

      // R3 row capture, R4 column and auto-close flag
      step(1'b1, 1'b0, SD_ACT, 1'b1, 11'h3AB, 1'b0);
      chk("R3 cmd_addr row", cmd_addr, 11'h3AB);
      chk("R3 cmd_banks", cmd_banks, 2'b10);
      // R9 write slots with mask pattern
      step(1'b1, 1'b0, SD_WR, 1'b1, 11'h35C, 1'b0);
      chk("R9 slot0 wr_en", s_wr_en, 1);
      chk("R4 cmd_addr col", cmd_addr, 11'h05C);
      chk("R4 cmd_autopre", cmd_autopre, 0);
      chk("R1 write code", cmd_code, SD_WR);
      step(1'b1, 1'b0, SD_NOP, 1'b0, '0, 1'b1);
      chk("R9 slot1 wr_mask", s_wr_mask, 1);
      chk("R9 slot1 wr_en", s_wr_en, 0);
      step(1'b1, 1'b0, SD_NOP, 1'b0, '0, 1'b0);
      chk("R9 slot2 wr_en", s_wr_en, 1);
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      chk("R2 R9 slot3 wr_en deselected", s_wr_en, 1);
      step(1'b1, 1'b0, SD_NOP, 1'b0, '0, 1'b1);
      chk("R9 after burst wr_en", s_wr_en, 0);
      chk("R9 after burst wr_mask", s_wr_mask, 0);

      // R10 burst stop ends a write burst
      step(1'b1, 1'b0, SD_WR, 1'b1, 11'h000, 1'b0);
      chk("R10 start wr_en", s_wr_en, 1);
      step(1'b1, 1'b0, SD_NOP, 1'b0, '0, 1'b0);
      chk("R10 slot1 wr_en", s_wr_en, 1);
      step(1'b1, 1'b0, SD_BST, 1'b0, '0, 1'b0);
      chk("R10 stop edge wr_en", s_wr_en, 0);
      step(1'b1, 1'b0, SD_NOP, 1'b0, '0, 1'b0);
      chk("R10 after stop wr_en", s_wr_en, 0);

      // R8 read mask latency
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b1);
      chk("R8 k+0 rd_hiz", rd_hiz, 0);
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      chk("R8 k+1 rd_hiz", rd_hiz, 1);
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      chk("R8 k+2 rd_hiz", rd_hiz, 0);

      // R7 auto-close countdown under deselect (R2)
      step(1'b1, 1'b0, SD_ACT, 1'b0, 11'h001, 1'b0);
      chk("R3 open bank0", bank_active, 2'b11);
      step(1'b1, 1'b0, SD_RD, 1'b0, 11'h412, 1'b0);
      chk("R4 read autopre", cmd_autopre, 1);
      chk("R7 k active", bank_active, 2'b11);
      for (int j = 1; j < BL; j++) begin
         step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
         chk($sformatf("R7 k+%0d active", j), bank_active, 2'b11);
         chk("R2 deselect cmd_valid", cmd_valid, 0);
      end
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      chk("R7 k+BL bank0 closed", bank_active, 2'b10);

      // R11 clock-enable freeze with one edge lag
      step(1'b0, 1'b0, SD_NOP, 1'b0, '0, 1'b0);
      step(1'b0, 1'b0, SD_ACT, 1'b0, 11'h002, 1'b1);
      chk("R11 frozen cmd_valid", cmd_valid, 0);
      chk("R11 frozen bank_active", bank_active, 2'b10);
      step(1'b1, 1'b0, SD_ACT, 1'b0, 11'h002, 1'b1);
      chk("R11 lag cmd_valid", cmd_valid, 0);
      chk("R11 lag bank_active", bank_active, 2'b10);
      chk("R11 frozen rd_hiz", rd_hiz, 0);
      step(1'b1, 1'b0, SD_ACT, 1'b0, 11'h002, 1'b0);
      chk("R11 resumed cmd_valid", cmd_valid, 1);
      chk("R11 resumed bank_active", bank_active, 2'b11);
      chk("R11 resumed rd_hiz", rd_hiz, 0);
      step(1'b1, 1'b0, SD_NOP, 1'b0, '0, 1'b0);
      chk("R11 no masked leak rd_hiz", rd_hiz, 0);

      // R12 self-refresh entry and exit
      step(1'b1, 1'b0, SD_PRE, 1'b0, 11'h400, 1'b0);
      chk("R5 all closed", bank_active, 2'b00);
      step(1'b0, 1'b0, SD_REF, 1'b0, '0, 1'b0);
      chk("R12 entry self_refresh", self_refresh, 1);
      chk("R12 entry cmd_code", cmd_code, SD_REF);
      step(1'b0, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      chk("R12 hold self_refresh", self_refresh, 1);
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);
      chk("R12 exit self_refresh", self_refresh, 0);
      step(1'b1, 1'b1, SD_NOP, 1'b0, '0, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule